// File: doc/BRIEF.md
# Oversampled Serial Receive Port

This block is the receive side of an asynchronous serial port, seen by software as three small registers. A tick input paces a 16x oversampler. The serial line is synchronised, and every bit is decided by a two-of-three vote over the samples around the bit centre. Frames carry 8 or 9 bits after the start bit. When parity is on, the last of those bits is the parity bit. Each character is placed in a data register and posts a ready flag.

The status word also reports the idle line, overrun, noise, framing and parity problems. The error and idle flags clear only when software reads the status register and then the data register. A single interrupt line is formed from the flags that can be enabled.

Register map (word addresses):

- 0 is status.
- 1 is receive data.
- 2 is control, with these bits:
  - bit0: receiver on
  - bit1: nine-bit frames
  - bit2: parity on
  - bit3: odd parity
  - bit4: ready/overrun interrupt enable
  - bit5: idle interrupt enable
  - bit6: parity interrupt enable

Top module: `serial_rx_port`

## Requirements
- R1: A frame (start bit 0, data LSB first, stop bit 1) is received in 8-bit mode (control bit1 = 0). Its value is then read at address 1 in bits 7:0, and status bit 5 (ready) is 1. Ready stays 1 until the data register is read.
- R2: With control bit1 = 1, nine bits are received and the data register returns them in bits 8:0.
- R3: With control bit2 = 1, the last received bit is the parity bit and reads back as the MSB of the data register (bit 7 or bit 8). Status bit 0 is set when the count of ones over all received bits is odd for even parity (bit3 = 0), or even for odd parity (bit3 = 1).
- R4: Each bit is taken by majority of three centre samples. Status bit 2 (noise) is set when those samples disagree on any bit of the frame, and the data is still correct.
- R5: A stop bit sampled as 0 sets status bit 1 (framing) and the character is still delivered.
- R6: A frame that completes while ready is 1 sets status bit 3 (overrun), keeps the old data and discards the new character. It leaves the framing flag unchanged even when the new stop bit is 0.
- R7: A data read alone clears only ready. Overrun, noise, framing, parity and idle clear only on a data read that follows a status read.
- R8: Status bit 4 (idle) is set after one full frame time of a high line. After it is cleared, it is not set again until a new character has been received.
- R9: irq_o is high when any of these holds: (ready or overrun) with bit4, idle with bit5, or parity error with bit6. Noise and framing never raise it.
- R10: A low pulse whose centre samples read 1 is a false start and delivers no character.
- R11: With control bit0 = 0, the line is ignored and no character is delivered.
- R12: After reset, status, control and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | oversampling strobe, 16 per bit |
| rxd_i | input | 1 | serial input line |
| rd_en_i | input | 1 | register read strobe |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 2 | register word address |
| wdata_i | input | 7 | control write data |
| rdata_o | output | 32 | register read data |
| irq_o | output | 1 | interrupt request |

## Verification
Two events can fall in the same cycle: the completion of a character whose stop bit is 0, and the overrun check against a ready flag that is still set. The bench provokes this by leaving one good character unread and then sending a character with a low stop bit. It then checks three things: overrun is set, framing is still clear, and the data register still holds the first character. A separate sequence reads data without a prior status read, to show that the error flags survive a bare data read.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  typedef struct packed {
    logic [8:0] data;
    logic       noise;
    logic       ferr;
    logic       perr;
  } rx_frame_t;

  // control word, bit0 = rx_en ... bit6 = par_ie
  typedef struct packed {
    logic par_ie;
    logic idle_ie;
    logic rdy_ie;
    logic par_odd;
    logic par_en;
    logic len9;
    logic rx_en;
  } rx_ctrl_t;

  localparam int unsigned CTRL_W    = $bits(rx_ctrl_t);
  localparam int unsigned ADDR_STAT = 0;
  localparam int unsigned ADDR_DATA = 1;
  localparam int unsigned ADDR_CTRL = 2;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 9
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      en_i,
  input  logic      len9_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o,
  output logic      idle_o
);
  localparam int CW       = $clog2(OSR);
  localparam int S_MID    = OSR / 2;
  localparam int S_A      = S_MID - 1;
  localparam int S_B      = S_MID + 1;
  localparam int BNW      = $clog2(MAX_BITS + 1);
  localparam int IDLE_MAX = OSR * (MAX_BITS + 2);
  localparam int IW       = $clog2(IDLE_MAX + 1);

  rx_state_e             state_q;
  logic [CW-1:0]         cnt_q, cnt_nx;
  logic [BNW-1:0]        bitn_q, nbits;
  logic [MAX_BITS-1:0]   sh_q;
  logic                  s_a_q, s_m_q, noise_q, par_q;
  logic                  vote, disagree;
  logic [IW-1:0]         icnt_q, idle_lim;

  assign nbits    = len9_i ? BNW'(MAX_BITS) : BNW'(MAX_BITS - 1);
  assign idle_lim = len9_i ? IW'(OSR * (MAX_BITS + 2)) : IW'(OSR * (MAX_BITS + 1));
  assign cnt_nx   = (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + 1'b1;
  // two-of-three vote; third sample is the live line
  assign vote     = (s_a_q & s_m_q) | (s_a_q & rx_i) | (s_m_q & rx_i);
  assign disagree = !((s_a_q == s_m_q) && (s_m_q == rx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      s_a_q   <= 1'b1;
      s_m_q   <= 1'b1;
      noise_q <= 1'b0;
      par_q   <= 1'b0;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        if (state_q != RX_IDLE) begin
          cnt_q <= cnt_nx;
          if (cnt_q == CW'(S_A))   s_a_q <= rx_i;
          if (cnt_q == CW'(S_MID)) s_m_q <= rx_i;
        end
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) begin
              state_q <= RX_START;
              noise_q <= 1'b0;
              par_q   <= 1'b0;
              bitn_q  <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(S_B)) begin
              if (vote) state_q <= RX_IDLE;  // false start
              else      noise_q <= noise_q | disagree;
            end
            if (cnt_q == CW'(OSR - 1)) state_q <= RX_BITS;
          end
          RX_BITS: begin
            if (cnt_q == CW'(S_B)) begin
              sh_q    <= {vote, sh_q[MAX_BITS-1:1]};
              par_q   <= par_q ^ vote;
              noise_q <= noise_q | disagree;
              bitn_q  <= bitn_q + 1'b1;
            end
            if (cnt_q == CW'(OSR - 1) && bitn_q == nbits) state_q <= RX_STOP;
          end
          RX_STOP: begin
            if (cnt_q == CW'(S_B)) begin
              done_o        <= 1'b1;
              frame_o.data  <= len9_i ? sh_q : {1'b0, sh_q[MAX_BITS-1:1]};
              frame_o.noise <= noise_q | disagree;
              frame_o.ferr  <= !vote;
              frame_o.perr  <= par_en_i & (par_q ^ par_odd_i);
              state_q       <= RX_IDLE;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // idle line: one full frame time of marks while waiting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      idle_o <= 1'b0;
    end else begin
      idle_o <= en_i && state_q == RX_IDLE && rx_i && tick_i && icnt_q == idle_lim - 1'b1;
      if (!en_i || state_q != RX_IDLE || !rx_i) icnt_q <= '0;
      else if (tick_i && icnt_q != idle_lim)    icnt_q <= icnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              idle_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [5:0]        flags_o   // {rdy, idle, ore, noise, ferr, perr}
);
  logic rdy_q, idle_q, ore_q, nf_q, fe_q, pe_q;
  logic armed_q, idle_arm_q;
  logic seq_clr, busy, accept;

  assign seq_clr = rd_data_i & armed_q;
  assign busy    = rdy_q & ~rd_data_i;  // a read in this cycle frees the holder
  assign accept  = done_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q      <= 1'b0;
      idle_q     <= 1'b0;
      ore_q      <= 1'b0;
      nf_q       <= 1'b0;
      fe_q       <= 1'b0;
      pe_q       <= 1'b0;
      armed_q    <= 1'b0;
      idle_arm_q <= 1'b0;
      data_o     <= '0;
    end else begin
      if (rd_data_i)      armed_q <= 1'b0;
      else if (rd_stat_i) armed_q <= 1'b1;

      if (accept) data_o <= frame_i.data[DATA_W-1:0];
      rdy_q  <= (rdy_q  & ~rd_data_i) | accept;
      ore_q  <= (ore_q  & ~seq_clr)   | (done_i & busy);
      nf_q   <= (nf_q   & ~seq_clr)   | (accept & frame_i.noise);
      fe_q   <= (fe_q   & ~seq_clr)   | (accept & frame_i.ferr);
      pe_q   <= (pe_q   & ~seq_clr)   | (accept & frame_i.perr);
      idle_q <= (idle_q & ~seq_clr)   | (idle_i & idle_arm_q);

      if (accept)                    idle_arm_q <= 1'b1;
      else if (idle_i && idle_arm_q) idle_arm_q <= 1'b0;
    end
  end

  assign flags_o = {rdy_q, idle_q, ore_q, nf_q, fe_q, pe_q};
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import srx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 9,
  parameter int AW       = 2,
  parameter int RW       = 32,
  parameter int SYNC     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [RW-1:0]     rdata_o,
  output logic              irq_o
);
  rx_ctrl_t            ctrl_q;
  logic                rx_s, done, idle_p;
  rx_frame_t           frame;
  logic [MAX_BITS-1:0] data;
  logic [5:0]          flags_w;
  logic                rd_stat, rd_data;

  assign rd_stat = rd_en_i && addr_i == AW'(ADDR_STAT);
  assign rd_data = rd_en_i && addr_i == AW'(ADDR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= '0;
    else if (wr_en_i && addr_i == AW'(ADDR_CTRL)) ctrl_q <= rx_ctrl_t'(wdata_i);
  end

  srx_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  srx_frame #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_s),
    .en_i(ctrl_q.rx_en), .len9_i(ctrl_q.len9), .par_en_i(ctrl_q.par_en),
    .par_odd_i(ctrl_q.par_odd), .done_o(done), .frame_o(frame), .idle_o(idle_p)
  );

  srx_flags #(.DATA_W(MAX_BITS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .frame_i(frame),
    .idle_i(idle_p), .rd_stat_i(rd_stat), .rd_data_i(rd_data),
    .data_o(data), .flags_o(flags_w)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(ADDR_STAT): rdata_o[5:0]          = flags_w;
      AW'(ADDR_DATA): rdata_o[MAX_BITS-1:0] = data;
      AW'(ADDR_CTRL): rdata_o[CTRL_W-1:0]   = ctrl_q;
      default:        rdata_o               = '0;
    endcase
  end

  // noise (bit2) and framing (bit1) are deliberately not sources
  assign irq_o = ((flags_w[5] | flags_w[3]) & ctrl_q.rdy_ie)
               | (flags_w[4] & ctrl_q.idle_ie)
               | (flags_w[0] & ctrl_q.par_ie);
endmodule

// File: rtl/serial_rx_port_chk.sv
module serial_rx_port_chk #(
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic          irq_o,
  input logic [5:0]    flags_i
);
  // R1
  rdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[5] && !(rd_en_i && addr_i == AW'(1))) |=> flags_i[5]);

  // R6
  ore_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[3]) |-> $past(flags_i[5]));

  // R6
  ore_no_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[3]) |-> !$rose(flags_i[1]));

  // R7
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flags_i[0]) || $fell(flags_i[1]) || $fell(flags_i[2]) || $fell(flags_i[3]) || $fell(flags_i[4]))
      |-> $past(rd_en_i && addr_i == AW'(1)));

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_i[5] || flags_i[4] || flags_i[3] || flags_i[0]));
endmodule

bind serial_rx_port serial_rx_port_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .addr_i(addr_i),
  .irq_o(irq_o), .flags_i(flags_w)
);

// File: tb/sim_serial_rx_port.sv
module sim_serial_rx_port;
  localparam int CLK_P = 10;
  localparam int OSR   = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        rxd_i = 1'b1;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [6:0]  wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  serial_rx_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [6:0] v);
    @(negedge clk_i);
    addr_i = 2'd2; wdata_i = v; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // glitch_bit: index of data bit to disturb for one sample, -1 for none
  task automatic send(input logic [8:0] v, input int nb, input logic stop_v, input int glitch_bit);
    for (int c = 0; c < OSR; c++) begin @(negedge clk_i); rxd_i = 1'b0; end
    for (int b = 0; b < nb; b++)
      for (int c = 0; c < OSR; c++) begin
        @(negedge clk_i);
        rxd_i = (b == glitch_bit && c == 9) ? ~v[b] : v[b];
      end
    for (int c = 0; c < OSR; c++) begin @(negedge clk_i); rxd_i = stop_v; end
    @(negedge clk_i); rxd_i = 1'b1;
    idle_cycles(4);
  endtask

  task automatic flush();
    logic [31:0] d;
    rd(2'd0, d);
    rd(2'd1, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R12 status", d, 0);
    rd(2'd2, d); check("R12 ctrl", d, 0);
    check("R12 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(7'h01); flush();
    send(9'h0A5, 8, 1'b1, -1);
    rd(2'd0, d); check("R1 ready", {31'b0, d[5]}, 1);
    check("R1 no errors", {28'b0, d[3:0]}, 0);
    rd(2'd1, d); check("R1 data", d, 32'hA5);
    rd(2'd0, d); check("R1 ready cleared", {31'b0, d[5]}, 0);
  endtask

  task automatic t_nine();
    logic [31:0] d;
    wr(7'h03); flush();
    send(9'h1C3, 9, 1'b1, -1);
    rd(2'd1, d); check("R2 nine-bit data", d, 32'h1C3);
  endtask

  task automatic t_parity();
    logic [31:0] d;
    wr(7'h05); flush();
    send(9'h0B5, 8, 1'b1, -1);
    rd(2'd0, d); check("R3 even bad pe", {31'b0, d[0]}, 1);
    rd(2'd1, d); check("R3 msb is parity", d, 32'hB5);
    flush();
    send(9'h035, 8, 1'b1, -1);
    rd(2'd0, d); check("R3 even good pe", {31'b0, d[0]}, 0);
    flush();
    wr(7'h0D);
    send(9'h0B5, 8, 1'b1, -1);
    rd(2'd0, d); check("R3 odd good pe", {31'b0, d[0]}, 0);
    flush();
    send(9'h035, 8, 1'b1, -1);
    rd(2'd0, d); check("R3 odd bad pe", {31'b0, d[0]}, 1);
    flush();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(7'h45); flush();
    check("R9 irq quiet", {31'b0, irq_o}, 0);
    send(9'h0B5, 8, 1'b1, -1);
    #1 check("R9 parity irq", {31'b0, irq_o}, 1);
    flush();
    #1 check("R9 parity irq cleared", {31'b0, irq_o}, 0);
    wr(7'h11);
    send(9'h011, 8, 1'b1, -1);
    #1 check("R9 ready irq", {31'b0, irq_o}, 1);
    rd(2'd1, d);
    #1 check("R9 ready irq cleared", {31'b0, irq_o}, 0);
  endtask

  task automatic t_noise();
    logic [31:0] d;
    wr(7'h41); flush();
    send(9'h05A, 8, 1'b1, 3);
    rd(2'd0, d); check("R4 noise flag", {31'b0, d[2]}, 1);
    check("R9 noise no irq", {31'b0, irq_o}, 0);
    rd(2'd1, d); check("R4 voted data", d, 32'h5A);
  endtask

  task automatic t_framing();
    logic [31:0] d;
    wr(7'h01); flush();
    send(9'h03C, 8, 1'b0, -1);
    idle_cycles(40);
    rd(2'd0, d); check("R5 framing flag", {31'b0, d[1]}, 1);
    check("R5 ready", {31'b0, d[5]}, 1);
    check("R10 no extra frame", {31'b0, d[3]}, 0);
    rd(2'd1, d); check("R5 data", d, 32'h3C);
  endtask

  // completion with low stop bit lands on a held character
  task automatic t_overrun();
    logic [31:0] d;
    flush();
    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b0, -1);
    rd(2'd0, d); check("R6 overrun", {31'b0, d[3]}, 1);
    check("R6 framing suppressed", {31'b0, d[1]}, 0);
    rd(2'd1, d); check("R6 old data kept", d, 32'h11);
    rd(2'd0, d); check("R6 overrun cleared", {31'b0, d[3]}, 0);
  endtask

  task automatic t_seq();
    logic [31:0] d;
    flush();
    send(9'h03C, 8, 1'b0, -1);
    rd(2'd1, d); check("R7 data read", d, 32'h3C);
    rd(2'd0, d); check("R7 fe survives bare read", {31'b0, d[1]}, 1);
    check("R7 ready cleared", {31'b0, d[5]}, 0);
    rd(2'd1, d);
    rd(2'd0, d); check("R7 fe cleared by sequence", {31'b0, d[1]}, 0);
  endtask

  task automatic t_idle();
    logic [31:0] d;
    wr(7'h21); flush();
    send(9'h077, 8, 1'b1, -1);
    idle_cycles(250);
    rd(2'd0, d); check("R8 idle set", {31'b0, d[4]}, 1);
    check("R9 idle irq", {31'b0, irq_o}, 1);
    rd(2'd1, d);
    idle_cycles(400);
    rd(2'd0, d); check("R8 idle not rearmed", {31'b0, d[4]}, 0);
    check("R8 irq low", {31'b0, irq_o}, 0);
    rd(2'd1, d);
  endtask

  task automatic t_false_start();
    logic [31:0] d;
    wr(7'h01); flush();
    @(negedge clk_i); rxd_i = 1'b0;
    idle_cycles(4);
    rxd_i = 1'b1;
    idle_cycles(300);
    rd(2'd0, d); check("R10 no char", {31'b0, d[5]}, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(7'h00); flush();
    send(9'h055, 8, 1'b1, -1);
    rd(2'd0, d); check("R11 disabled", {31'b0, d[5]}, 0);
    wr(7'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle_cycles(2);
    t_reset();
    t_basic();
    t_nine();
    t_parity();
    t_irq();
    t_noise();
    t_framing();
    t_overrun();
    t_seq();
    t_idle();
    t_false_start();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule